// File: doc/BRIEF.md
# Out-of-Order Dispatch Gate with In-Order Retirement Buffer

This block sits between a queue of already-decoded instructions and the schedulers of an out-of-order core. Each cycle it looks at up to `LANES` decoded instructions, with lane 0 the oldest. It takes the longest run of them, in program order, that fits the free resources. An instruction needs one retirement-buffer entry per micro-op and one physical register per destination. It also needs the scheduler to be able to accept work. The block does no renaming itself; it only keeps the budgets.

Each dispatched instruction gets a tag, which is the index of its record in a circular buffer. An execution side reports completion by presenting that tag on a write-back port. Retirement takes completed instructions from the oldest end only, at most `RET_W` per cycle. When an instruction retires, its micro-op entries and its registers go back to the free pools.

The decoded-instruction input is a per-lane valid/ready stream. A lane counts as transferred when its `in_valid` and `in_ready` are both high in the same cycle. `in_ready` depends on that cycle's lane contents and is never high for an invalid lane. A lane that is refused must be offered again in a later cycle, together with every younger lane. Lanes must carry a micro-op count of at least one. `DEPTH` must be a power of two.

Top module: `dispatch_rob_gate`

## Requirements
- R1: Lanes are considered oldest first, starting at lane 0. `in_ready[i]` is high only if `in_valid[i]` is high and every lane below i is also taken. The first lane that is not taken ends the group, even if younger lanes would fit.
- R2: A lane is taken only if the micro-op counts of the group, summed up to and including that lane, do not exceed the free buffer entries. The free count is `DEPTH` minus the micro-ops of all instructions still in flight.
- R3: A lane is taken only if the destination counts of the group, summed up to and including that lane, do not exceed the free physical registers. The free count is `PREGS` minus the destinations held in flight. With `PREGS` = 0 this check is switched off and registers are unlimited.
- R4: While `sched_full` is high, no lane is taken.
- R5: Taken lane i is given tag (T + i) mod `DEPTH`, reported on `disp_tag` slice i. T is the tail pointer: it starts at 0 after reset and advances by the number of lanes taken in each cycle.
- R6: A write-back with tag t marks instruction t as completed. That instruction can retire no earlier than the next cycle.
- R7: `ret_valid[j]` is high exactly when the j+1 oldest in-flight instructions are all completed, for j below `RET_W`. `ret_tag` slice j then holds (H + j) mod `DEPTH`, where H is the tag of the oldest instruction in flight.
- R8: A retiring instruction returns its micro-op entries and its destination registers to the pools at the clock edge. Dispatch sees the returned budget from the next cycle on, not in the cycle of retirement.
- R9: A synchronous reset empties the buffer, sets both tag pointers to 0 and refills both pools. While reset is high, `in_ready` and `ret_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | LANES | Lane holds a decoded instruction; bit 0 is oldest |
| in_uops | input | LANES*3 | Micro-op count per lane, 1..7, lane i at bits [3i+2:3i] |
| in_dsts | input | LANES*2 | Destination-register count per lane, 0..3, lane i at bits [2i+1:2i] |
| in_ready | output | LANES | Lane is taken this cycle |
| disp_tag | output | LANES*log2(DEPTH) | Tag given to each taken lane |
| sched_full | input | 1 | Scheduler cannot accept work this cycle |
| wb_valid | input | WB_N | Write-back port carries a completion |
| wb_tag | input | WB_N*log2(DEPTH) | Tag of the completing instruction per port |
| ret_valid | output | RET_W | Retirement slot j retires an instruction this cycle |
| ret_tag | output | RET_W*log2(DEPTH) | Tag retired in each slot |

## Verification
The bench runs two instances side by side: one with a finite register budget and one with `PREGS` = 0. Both are fed the same lanes.

Several input patterns are used:
- Valid patterns with gaps show whether a group really ends at the first idle lane instead of skipping over it.
- Long runs of 4-to-7 micro-op instructions with rare write-backs fill the buffer. They separate a refusal caused by buffer entries from one caused by registers.
- Runs of three-destination instructions exhaust the register pool on the bounded instance while the unbounded one keeps dispatching.
- Scheduler-full pulses are mixed in throughout.
- Drain phases complete everything out of order, which exposes whether retirement waits for the oldest entry and whether two instructions can retire in one cycle.

A mid-run reset checks that state is restored.

// File: rtl/dgr_pkg.sv
package dgr_pkg;
  localparam int LANE_UOP_W = 3;
  localparam int LANE_DST_W = 2;

  typedef struct packed {
    logic [LANE_UOP_W-1:0] uops;
    logic [LANE_DST_W-1:0] dsts;
    logic                  done;
  } rob_rec_t;
endpackage

// File: rtl/dgr_select.sv
module dgr_select #(
  parameter int LANES = 4,
  parameter int CW    = 8,
  parameter int PREGS = 24
) (
  input  logic                                  halt,
  input  logic                                  sched_full,
  input  logic [LANES-1:0]                      in_valid,
  input  logic [LANES*dgr_pkg::LANE_UOP_W-1:0]  in_uops,
  input  logic [LANES*dgr_pkg::LANE_DST_W-1:0]  in_dsts,
  input  logic [CW-1:0]                         free_uops,
  input  logic [CW-1:0]                         free_regs,
  output logic [LANES-1:0]                      take,
  output logic [CW-1:0]                         grp_uops,
  output logic [CW-1:0]                         grp_dsts
);
  import dgr_pkg::*;

  logic [CW-1:0] cu [LANES+1];
  logic [CW-1:0] cd [LANES+1];
  logic [LANES:0] go;

  assign cu[0] = '0;
  assign cd[0] = '0;
  assign go[0] = !halt && !sched_full;

  // Running sums: a lane may join only if the sums through it still fit.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CW-1:0] nu, nd;
    logic          fit_u, fit_r;
    assign nu      = cu[g] + CW'(in_uops[g*LANE_UOP_W +: LANE_UOP_W]);
    assign nd      = cd[g] + CW'(in_dsts[g*LANE_DST_W +: LANE_DST_W]);
    assign fit_u   = nu <= free_uops;
    assign fit_r   = (PREGS == 0) || (nd <= free_regs);
    assign take[g] = go[g] && in_valid[g] && fit_u && fit_r;
    assign go[g+1] = take[g];
    assign cu[g+1] = take[g] ? nu : cu[g];
    assign cd[g+1] = take[g] ? nd : cd[g];
  end

  assign grp_uops = cu[LANES];
  assign grp_dsts = cd[LANES];
endmodule

// File: rtl/dgr_pool.sv
module dgr_pool #(
  parameter int CAP = 16,
  parameter int CW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] take_n,
  input  logic [CW-1:0] give_n,
  output logic [CW-1:0] free_n
);
  always_ff @(posedge clk) begin
    if (rst) free_n <= CW'(CAP);
    else     free_n <= free_n - take_n + give_n;
  end

  // R8: returned credits never push the pool above its capacity
  p_pool_bound_r8: assert property (@(posedge clk) disable iff (rst)
    free_n <= CW'(CAP));
  // R2 / R3: the dispatch side never draws more than is free
  p_no_overdraw_r2: assert property (@(posedge clk) disable iff (rst)
    take_n <= free_n);
endmodule

// File: rtl/dgr_rob.sv
module dgr_rob #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int RET_W = 2,
  parameter int WB_N  = 2,
  parameter int CW    = 8,
  localparam int TW   = $clog2(DEPTH)
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [LANES-1:0]                     take,
  input  logic [LANES*dgr_pkg::LANE_UOP_W-1:0] in_uops,
  input  logic [LANES*dgr_pkg::LANE_DST_W-1:0] in_dsts,
  input  logic [WB_N-1:0]                      wb_valid,
  input  logic [WB_N*TW-1:0]                   wb_tag,
  output logic [LANES*TW-1:0]                  disp_tag,
  output logic [RET_W-1:0]                     ret_valid,
  output logic [RET_W*TW-1:0]                  ret_tag,
  output logic [CW-1:0]                        ret_uops,
  output logic [CW-1:0]                        ret_dsts
);
  import dgr_pkg::*;

  rob_rec_t      recs [DEPTH];
  logic [TW-1:0] head;
  logic [TW:0]   occ;
  logic [TW-1:0] tail;
  logic [TW:0]   n_take, n_ret;

  assign tail = head + occ[TW-1:0];

  for (genvar g = 0; g < LANES; g++) begin : g_tag
    assign disp_tag[g*TW +: TW] = tail + TW'(g);
  end

  // Retirement: a prefix of completed records starting at the oldest.
  logic [RET_W:0] rgo;
  logic [CW-1:0]  su [RET_W+1];
  logic [CW-1:0]  sd [RET_W+1];
  assign rgo[0] = !rst;
  assign su[0]  = '0;
  assign sd[0]  = '0;

  for (genvar j = 0; j < RET_W; j++) begin : g_ret
    logic [TW-1:0] slot;
    assign slot                = head + TW'(j);
    assign ret_valid[j]        = rgo[j] && (occ > (TW+1)'(j)) && recs[slot].done;
    assign rgo[j+1]            = ret_valid[j];
    assign ret_tag[j*TW +: TW] = slot;
    assign su[j+1] = ret_valid[j] ? su[j] + CW'(recs[slot].uops) : su[j];
    assign sd[j+1] = ret_valid[j] ? sd[j] + CW'(recs[slot].dsts) : sd[j];
  end

  assign ret_uops = su[RET_W];
  assign ret_dsts = sd[RET_W];
  assign n_take   = (TW+1)'($countones(take));
  assign n_ret    = (TW+1)'($countones(ret_valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      head <= '0;
      occ  <= '0;
      for (int k = 0; k < DEPTH; k++) recs[k].done <= 1'b0;
    end else begin
      head <= head + n_ret[TW-1:0];
      occ  <= occ + n_take - n_ret;
      for (int g = 0; g < LANES; g++) begin
        if (take[g]) begin
          recs[tail + TW'(g)] <= '{uops: in_uops[g*LANE_UOP_W +: LANE_UOP_W],
                                   dsts: in_dsts[g*LANE_DST_W +: LANE_DST_W],
                                   done: 1'b0};
        end
      end
      for (int w = 0; w < WB_N; w++) begin
        if (wb_valid[w]) recs[wb_tag[w*TW +: TW]].done <= 1'b1;
      end
    end
  end

  // R6: a completion names a live, not yet completed instruction
  for (genvar w = 0; w < WB_N; w++) begin : g_wbchk
    p_wb_live_r6: assert property (@(posedge clk) disable iff (rst)
      wb_valid[w] |-> (!recs[wb_tag[w*TW +: TW]].done &&
                       ({1'b0, wb_tag[w*TW +: TW] - head} < occ)));
  end

  // R7: occupancy stays within the record ring
  p_occ_bound_r7: assert property (@(posedge clk) disable iff (rst)
    occ <= (TW+1)'(DEPTH));
endmodule

// File: rtl/dispatch_rob_gate.sv
module dispatch_rob_gate #(
  parameter int DEPTH = 16,
  parameter int LANES = 4,
  parameter int RET_W = 2,
  parameter int WB_N  = 2,
  parameter int PREGS = 24,
  localparam int TW   = $clog2(DEPTH),
  localparam int UW   = dgr_pkg::LANE_UOP_W,
  localparam int DW   = dgr_pkg::LANE_DST_W,
  localparam int CW   = $clog2(DEPTH + PREGS + LANES * (2**UW) + LANES * (2**DW) + 1) + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [LANES-1:0]    in_valid,
  input  logic [LANES*UW-1:0] in_uops,
  input  logic [LANES*DW-1:0] in_dsts,
  output logic [LANES-1:0]    in_ready,
  output logic [LANES*TW-1:0] disp_tag,
  input  logic                sched_full,
  input  logic [WB_N-1:0]     wb_valid,
  input  logic [WB_N*TW-1:0]  wb_tag,
  output logic [RET_W-1:0]    ret_valid,
  output logic [RET_W*TW-1:0] ret_tag
);
  localparam bit REG_LIMIT = (PREGS != 0);
  localparam int REG_CAP   = REG_LIMIT ? PREGS : 0;

  logic [CW-1:0] free_uops, free_regs;
  logic [CW-1:0] grp_uops, grp_dsts;
  logic [CW-1:0] ret_uops, ret_dsts;
  logic [CW-1:0] reg_take, reg_give;

  dgr_select #(.LANES(LANES), .CW(CW), .PREGS(PREGS)) u_sel (
    .halt(rst), .sched_full(sched_full), .in_valid(in_valid),
    .in_uops(in_uops), .in_dsts(in_dsts),
    .free_uops(free_uops), .free_regs(free_regs),
    .take(in_ready), .grp_uops(grp_uops), .grp_dsts(grp_dsts)
  );

  dgr_rob #(.DEPTH(DEPTH), .LANES(LANES), .RET_W(RET_W), .WB_N(WB_N), .CW(CW)) u_rob (
    .clk(clk), .rst(rst), .take(in_ready), .in_uops(in_uops), .in_dsts(in_dsts),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .disp_tag(disp_tag),
    .ret_valid(ret_valid), .ret_tag(ret_tag),
    .ret_uops(ret_uops), .ret_dsts(ret_dsts)
  );

  dgr_pool #(.CAP(DEPTH), .CW(CW)) u_uop_pool (
    .clk(clk), .rst(rst), .take_n(grp_uops), .give_n(ret_uops), .free_n(free_uops)
  );

  // Unbounded variant: the register pool holds no credit and is never drawn.
  assign reg_take = REG_LIMIT ? grp_dsts : '0;
  assign reg_give = REG_LIMIT ? ret_dsts : '0;

  dgr_pool #(.CAP(REG_CAP), .CW(CW)) u_reg_pool (
    .clk(clk), .rst(rst), .take_n(reg_take), .give_n(reg_give), .free_n(free_regs)
  );

  // R1: a taken lane implies every older lane was taken
  for (genvar g = 1; g < LANES; g++) begin : g_pfx
    p_prefix_r1: assert property (@(posedge clk) disable iff (rst)
      in_ready[g] |-> in_ready[g-1]);
  end

  // R4: nothing enters while the scheduler is full
  p_sched_block_r4: assert property (@(posedge clk) disable iff (rst)
    sched_full |-> (in_ready == '0));

  // R2: group micro-ops fit the free buffer entries
  p_rob_room_r2: assert property (@(posedge clk) disable iff (rst)
    grp_uops <= free_uops);

  // R3: group destinations fit the register budget when one is set
  p_reg_room_r3: assert property (@(posedge clk) disable iff (rst)
    !REG_LIMIT || (grp_dsts <= free_regs));

  // R1: only valid lanes are ever taken
  p_ready_valid_r1: assert property (@(posedge clk) disable iff (rst)
    (in_ready & ~in_valid) == '0);
endmodule

// File: tb/sim_dispatch_rob_gate.sv
module sim_dispatch_rob_gate;
  localparam int CLK_PERIOD = 10;
  localparam int D  = 16;
  localparam int L  = 4;
  localparam int RW = 2;
  localparam int WN = 2;
  localparam int PB = 24;
  localparam int TW = 4;
  localparam int UW = 3;
  localparam int DW = 2;
  localparam int NCYC = 2600;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [L-1:0]    in_valid = '0;
  logic [L*UW-1:0] in_uops  = '0;
  logic [L*DW-1:0] in_dsts  = '0;
  logic            sched_full = 1'b0;
  logic [WN-1:0]    wbv [2];
  logic [WN*TW-1:0] wbt [2];
  logic [L-1:0]     rdy [2];
  logic [L*TW-1:0]  dtg [2];
  logic [RW-1:0]    rtv [2];
  logic [RW*TW-1:0] rtt [2];

  dispatch_rob_gate #(.DEPTH(D), .LANES(L), .RET_W(RW), .WB_N(WN), .PREGS(PB)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_ready(rdy[0]), .disp_tag(dtg[0]), .sched_full(sched_full),
    .wb_valid(wbv[0]), .wb_tag(wbt[0]), .ret_valid(rtv[0]), .ret_tag(rtt[0]));

  dispatch_rob_gate #(.DEPTH(D), .LANES(L), .RET_W(RW), .WB_N(WN), .PREGS(0)) u1 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops), .in_dsts(in_dsts),
    .in_ready(rdy[1]), .disp_tag(dtg[1]), .sched_full(sched_full),
    .wb_valid(wbv[1]), .wb_tag(wbt[1]), .ret_valid(rtv[1]), .ret_tag(rtt[1]));

  // Behavioural reference: per instance, a ring of in-flight records and two budgets.
  int fu [2];
  int fr [2];
  int hd [2];
  int cn [2];
  int mu [2][D];
  int md [2][D];
  bit mdn [2][D];

  int  vectors = 0;
  int  misses  = 0;
  bit  finished = 1'b0;

  task automatic model_reset(int m);
    fu[m] = D; fr[m] = PB; hd[m] = 0; cn[m] = 0;
    for (int k = 0; k < D; k++) mdn[m][k] = 1'b0;
  endtask

  task automatic pick_wb(int m, int pct);
    int cand [D];
    int nc;
    wbv[m] = '0; wbt[m] = '0; nc = 0;
    for (int j = 0; j < cn[m]; j++) begin
      int s;
      s = (hd[m] + j) % D;
      if (!mdn[m][s]) begin cand[nc] = s; nc++; end
    end
    for (int w = 0; w < WN; w++) begin
      if (nc > 0 && ($urandom % 100) < pct) begin
        int p;
        p = $urandom % nc;
        wbv[m][w] = 1'b1;
        wbt[m][w*TW +: TW] = TW'(cand[p]);
        cand[p] = cand[nc-1];
        nc--;
      end
    end
  endtask

  task automatic check_and_step(int m, int cyc);
    bit run, rr;
    int su, sd, tail0, nret, plim;
    logic [L-1:0] er;
    logic [RW-1:0] ev;
    plim = (m == 0) ? PB : 0;
    er = '0; ev = '0; su = 0; sd = 0;
    tail0 = (hd[m] + cn[m]) % D;
    run = !sched_full && !rst;
    for (int i = 0; i < L; i++) begin
      int u, d;
      u = int'(in_uops[i*UW +: UW]);
      d = int'(in_dsts[i*DW +: DW]);
      if (run && in_valid[i] && (su + u <= fu[m]) && (plim == 0 || sd + d <= fr[m])) begin
        er[i] = 1'b1; su += u; sd += d;
      end else run = 1'b0;
    end
    rr = !rst;
    for (int j = 0; j < RW; j++) begin
      if (rr && j < cn[m] && mdn[m][(hd[m] + j) % D]) ev[j] = 1'b1;
      else rr = 1'b0;
    end

    vectors++;
    if (rst) begin
      // R9: outputs quiet during reset
      if (rdy[m] !== '0 || rtv[m] !== '0) begin
        misses++;
        $display("FAIL R9 inst %0d cycle %0d ready/ret got %b/%b exp 0/0", m, cyc, rdy[m], rtv[m]);
      end
    end else begin
      // R1 R2 R3 R4 R8: group grant
      if (rdy[m] !== er) begin
        misses++;
        $display("FAIL R1 R2 R3 R4 R8 inst %0d cycle %0d in_ready got %b exp %b", m, cyc, rdy[m], er);
      end
      // R5: tags of taken lanes
      for (int i = 0; i < L; i++) begin
        if (er[i] && dtg[m][i*TW +: TW] !== TW'((tail0 + i) % D)) begin
          misses++;
          $display("FAIL R5 inst %0d cycle %0d lane %0d tag got %0d exp %0d", m, cyc, i,
                   dtg[m][i*TW +: TW], (tail0 + i) % D);
        end
      end
      // R6 R7: in-order retirement of completed records
      if (rtv[m] !== ev) begin
        misses++;
        $display("FAIL R6 R7 inst %0d cycle %0d ret_valid got %b exp %b", m, cyc, rtv[m], ev);
      end
      for (int j = 0; j < RW; j++) begin
        if (ev[j] && rtt[m][j*TW +: TW] !== TW'((hd[m] + j) % D)) begin
          misses++;
          $display("FAIL R7 inst %0d cycle %0d ret_tag[%0d] got %0d exp %0d", m, cyc, j,
                   rtt[m][j*TW +: TW], (hd[m] + j) % D);
        end
      end
    end

    // State update for the coming edge
    if (rst) model_reset(m);
    else begin
      nret = 0;
      for (int j = 0; j < RW; j++) begin
        if (ev[j]) begin
          int s;
          s = (hd[m] + j) % D;
          fu[m] += mu[m][s]; fr[m] += md[m][s]; nret++;
        end
      end
      for (int w = 0; w < WN; w++)
        if (wbv[m][w]) mdn[m][int'(wbt[m][w*TW +: TW])] = 1'b1;
      for (int i = 0; i < L; i++) begin
        if (er[i]) begin
          int s;
          s = (tail0 + i) % D;
          mu[m][s] = int'(in_uops[i*UW +: UW]);
          md[m][s] = int'(in_dsts[i*DW +: DW]);
          mdn[m][s] = 1'b0;
        end
      end
      fu[m] -= su; fr[m] -= sd;
      hd[m] = (hd[m] + nret) % D;
      cn[m] = cn[m] + $countones(er) - nret;
    end
  endtask

  task automatic drive(int ulo, int uhi, int dlo, int dhi, int vpct, int spct);
    for (int i = 0; i < L; i++) begin
      in_valid[i] = (($urandom % 100) < vpct);
      in_uops[i*UW +: UW] = UW'(ulo + ($urandom % (uhi - ulo + 1)));
      in_dsts[i*DW +: DW] = DW'(dlo + ($urandom % (dhi - dlo + 1)));
    end
    sched_full = (($urandom % 100) < spct);
  endtask

  initial begin
    int wpct;
    model_reset(0); model_reset(1);
    wbv[0] = '0; wbv[1] = '0; wbt[0] = '0; wbt[1] = '0;
    @(negedge clk);
    for (int c = 0; c < NCYC; c++) begin
      rst = (c < 2) || (c == 1700) || (c == 1701);
      wpct = 60;
      if (c < 500)       drive(1, 3, 0, 2, 75, 10);   // mixed, gaps in lanes
      else if (c < 900)  begin drive(4, 7, 0, 1, 90, 5); wpct = 10; end  // buffer pressure
      else if (c < 1300) begin drive(1, 1, 3, 3, 90, 5); wpct = 15; end  // register pressure
      else if (c < 1600) begin drive(1, 2, 0, 3, 5, 0);  wpct = 100; end // drain, multi-retire
      else               drive(1, 7, 0, 3, 70, 15);    // mixed after reset
      for (int m = 0; m < 2; m++) begin
        if (rst) begin wbv[m] = '0; wbt[m] = '0; end
        else pick_wb(m, wpct);
      end
      #1;
      for (int m = 0; m < 2; m++) check_and_step(m, c);
      @(posedge clk);
      @(negedge clk);
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      misses++;
      $display("FAIL watchdog expired got running exp finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule